// File: doc/BRIEF.md
# Serial Reprogramming Sequencer for a Flash-Based Target Device

This block rewrites the non-volatile configuration of a target device over a four-wire serial link, with no processor involved. It acts as the SPI master and runs a fixed sequence of commands. It first reads back the target's identity and checks it against an expected value. It then puts the target into programming mode and streams the configuration image in fixed-size frames. After every frame it polls the target's status. It then takes the target out of programming mode, releases the link and compares the device serial number against an expected value. Any failure stops the sequence at once and leaves a result code.

A start pulse launches the sequence. The expected identity and serial number are captured when the start is accepted. Image bytes arrive on a valid/ready byte stream. A byte is taken on a clock edge where both `img_valid_i` and `img_ready_o` are high. A source that has raised valid keeps it raised, with data and last unchanged, until the byte is taken. `img_ready_o` is raised only while the sequencer is gathering the next frame, so the source is held back during every serial transfer and while the block is idle. `img_last_i` marks the final image byte.

Top module: `spi_prog_seq`

## Requirements
- R1: Every transfer is exactly 17 bytes, which is 136 rising edges of `spi_sclk_o`. `spi_cs_n_o` stays low for the whole transfer and goes high between transfers, and `spi_sclk_o` is low whenever `spi_cs_n_o` is high.
- R2: The link uses clock mode 0 with the most significant bit first. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. A transfer sends an opcode byte and then payload bytes 0 to 15 in order. Every transfer other than image data carries an all-zero payload.
- R3: Opcodes go out in this fixed order: 0x30, 0x06, 0x14, then for each image frame a data transfer (opcode DATA_OP, default 0x01) followed by one or more status polls (opcode STAT_OP, default 0x05), then 0x15, 0x23 and finally 0x18.
- R4: Response payload bytes 0 to 3 of the 0x30 transfer form the device identity, with byte 0 as the most significant byte. If this differs from `exp_id_i`, no further transfer is made and the result is code 1.
- R5: A data transfer's payload is the next 16 image bytes in arrival order. The frame that ends with the `img_last_i` byte is padded with zero bytes up to 16.
- R6: Image bytes move only on a valid and ready edge. Ready is low while idle, during any transfer and after an abort, and a successful run consumes exactly the image length.
- R7: Status response payload byte 0 decides the next step. The value 0x00 means go on to the next frame, or to 0x15 after the last frame. The value 0x01 means busy, so the poll is repeated. Any other value stops the sequence with code 2.
- R8: If a poll reports busy once TIMEOUT_CYC clock cycles have passed since that frame's polling began, the sequence stops with code 3.
- R9: Response payload bytes 0 to 3 of the 0x18 transfer are compared with `exp_sn_i`, with byte 0 as the most significant byte. A match ends the run with `done_o`=1, `error_o`=0 and code 0. A mismatch ends it with `error_o`=1 and code 4.
- R10: `done_o`, `error_o` and `err_code_o` hold their values until the next accepted start, and no transfer occurs in that time. A start that arrives while a run is in progress is ignored, and so are changes to `exp_id_i` and `exp_sn_i` after the run was accepted.
- R11: After reset `spi_cs_n_o`=1, `spi_sclk_o`=0, `img_ready_o`=0, `done_o`=0, `error_o`=0 and `err_code_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a run when idle |
| exp_id_i | input | ID_W | Expected device identity |
| exp_sn_i | input | SN_W | Expected device serial number |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte present |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Sequencer takes an image byte this cycle |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the target |
| spi_cs_n_o | output | 1 | Active-low target select |
| spi_miso_i | input | 1 | Serial data from the target |
| done_o | output | 1 | Run finished (success or abort) |
| error_o | output | 1 | Run ended in failure |
| err_code_o | output | 4 | 0 ok, 1 identity, 2 bad status, 3 busy timeout, 4 serial |

## Verification
A model of the target device answers each opcode. It records every opcode, payload and bit count so the sequence can be compared with one built from the requirements. Image lengths of 1, 16, 17 and 64 bytes, together with random lengths, separate correct frame splitting from errors in padding and off-by-one frame counts. Random busy counts per frame, a rejected status, a target that stays busy forever, and wrong identity or serial values tell the repeat-poll path apart from the abort paths and show that each abort happens at the right point. A stream with random gaps, and a second start with altered expected values in the middle of a run, show that back-pressure holds and that inputs are captured only once.

// File: rtl/spq_pkg.sv
`timescale 1ns/1ps
package spq_pkg;
  localparam int FRAME_BYTES = 16;
  localparam int XFER_BYTES  = FRAME_BYTES + 1;

  localparam logic [7:0] OP_READ_BUF = 8'h30;
  localparam logic [7:0] OP_MODE_SET = 8'h06;
  localparam logic [7:0] OP_PROG_ON  = 8'h14;
  localparam logic [7:0] OP_PROG_OFF = 8'h15;
  localparam logic [7:0] OP_RELEASE  = 8'h23;
  localparam logic [7:0] OP_SERIAL   = 8'h18;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_ID      = 4'd1,
    ERR_STATUS  = 4'd2,
    ERR_TIMEOUT = 4'd3,
    ERR_SERIAL  = 4'd4
  } spq_err_e;

  typedef enum logic [2:0] {
    STEP_RDBUF, STEP_MODE, STEP_PEN, STEP_DATA,
    STEP_POLL, STEP_PDIS, STEP_REL, STEP_SN
  } spq_step_e;

  typedef enum logic [1:0] {C_IDLE, C_FILL, C_LAUNCH, C_WAIT} spq_ctl_e;

  typedef enum logic [2:0] {E_IDLE, E_LOW, E_HIGH, E_TAIL, E_GAP} spq_eng_e;
endpackage

// File: rtl/spq_spi_engine.sv
`timescale 1ns/1ps
module spq_spi_engine
  import spq_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int CS_GAP   = 4,
  parameter int NBYTES   = 17,
  parameter int RXW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [NBYTES*8-1:0]   tx_i,
  output logic                  ready_o,
  output logic                  done_o,
  output logic [RXW-1:0]        rx_o,
  output logic                  sclk_o,
  output logic                  mosi_o,
  output logic                  cs_n_o,
  input  logic                  miso_i
);
  localparam int NBITS = NBYTES * 8;
  localparam int BW    = $clog2(NBITS);
  localparam int MAXC  = (DIV_HALF > CS_GAP) ? DIV_HALF : CS_GAP;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(DIV_HALF - 1);
  localparam logic [CW-1:0] GAP_M1  = CW'(CS_GAP - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(NBITS - 1);
  localparam logic [BW-1:0] CAP_LO  = BW'(8);
  localparam logic [BW-1:0] CAP_HI  = BW'(8 + RXW);

  spq_eng_e             st_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bit_q;
  logic [NBITS-1:0]     sr_q;
  logic [RXW-1:0]       rx_q;
  logic                 sclk_q, mosi_q, cs_n_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        E_IDLE: if (go_i) begin
          sr_q   <= tx_i;
          mosi_q <= tx_i[NBITS-1];
          cs_n_q <= 1'b0;
          cnt_q  <= '0;
          bit_q  <= '0;
          st_q   <= E_LOW;
        end
        E_LOW: if (cnt_q == HALF_M1) begin
          cnt_q  <= '0;
          sclk_q <= 1'b1;
          if (bit_q >= CAP_LO && bit_q < CAP_HI) rx_q <= {rx_q[RXW-2:0], miso_i};
          st_q   <= E_HIGH;
        end else cnt_q <= cnt_q + 1'b1;
        E_HIGH: if (cnt_q == HALF_M1) begin
          cnt_q  <= '0;
          sclk_q <= 1'b0;
          if (bit_q == LASTBIT) st_q <= E_TAIL;
          else begin
            sr_q   <= {sr_q[NBITS-2:0], 1'b0};
            mosi_q <= sr_q[NBITS-2];
            bit_q  <= bit_q + 1'b1;
            st_q   <= E_LOW;
          end
        end else cnt_q <= cnt_q + 1'b1;
        E_TAIL: if (cnt_q == HALF_M1) begin
          cnt_q  <= '0;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          st_q   <= E_GAP;
        end else cnt_q <= cnt_q + 1'b1;
        E_GAP: if (cnt_q == GAP_M1) begin
          cnt_q <= '0;
          st_q  <= E_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == E_IDLE);
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign sclk_o  = sclk_q;
  assign mosi_o  = mosi_q;
  assign cs_n_o  = cs_n_q;

  // Checker support: rising clock edges seen inside one select window
  logic          sclk_d;
  logic [BW:0]   rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (cs_n_q) rise_cnt <= '0;
      else if (sclk_q && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q);
  p_bit_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> rise_cnt == (BW+1)'(NBITS));
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_q) |-> !sclk_q);
endmodule

// File: rtl/spq_ctrl.sv
`timescale 1ns/1ps
module spq_ctrl
  import spq_pkg::*;
#(
  parameter int         ID_W        = 32,
  parameter int         SN_W        = 32,
  parameter int         TIMEOUT_CYC = 1000000,
  parameter logic [7:0] DATA_OP     = 8'h01,
  parameter logic [7:0] STAT_OP     = 8'h05,
  parameter logic [7:0] STAT_OK     = 8'h00,
  parameter logic [7:0] STAT_BUSY   = 8'h01,
  parameter int         CAPW        = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [ID_W-1:0]             exp_id_i,
  input  logic [SN_W-1:0]             exp_sn_i,
  input  logic [7:0]                  img_data_i,
  input  logic                        img_valid_i,
  input  logic                        img_last_i,
  output logic                        img_ready_o,
  input  logic                        eng_ready_i,
  input  logic                        eng_done_i,
  input  logic [CAPW-1:0]             eng_rx_i,
  output logic                        eng_go_o,
  output logic [XFER_BYTES*8-1:0]     eng_tx_o,
  output logic                        done_o,
  output logic                        error_o,
  output logic [3:0]                  err_code_o
);
  localparam int FIW = $clog2(FRAME_BYTES);
  localparam int TW  = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [TW-1:0]  T_LIM   = TW'(TIMEOUT_CYC);
  localparam logic [TW-1:0]  T_MAX   = '1;
  localparam logic [FIW-1:0] FI_LAST = FIW'(FRAME_BYTES - 1);

  spq_ctl_e                        st_q;
  spq_step_e                       step_q;
  logic [0:FRAME_BYTES-1][7:0]     pay_q;
  logic [FIW-1:0]                  fidx_q;
  logic                            last_q;
  logic [TW-1:0]                   timer_q;
  logic [ID_W-1:0]                 id_q;
  logic [SN_W-1:0]                 sn_q;
  logic                            done_q, err_q;
  spq_err_e                        code_q;
  logic [7:0]                      opcode;

  wire [ID_W-1:0] rx_id  = eng_rx_i[CAPW-1 -: ID_W];
  wire [SN_W-1:0] rx_sn  = eng_rx_i[CAPW-1 -: SN_W];
  wire [7:0]      rx_st  = eng_rx_i[CAPW-1 -: 8];
  wire            running = (st_q != C_IDLE);

  always_comb begin
    case (step_q)
      STEP_RDBUF: opcode = OP_READ_BUF;
      STEP_MODE:  opcode = OP_MODE_SET;
      STEP_PEN:   opcode = OP_PROG_ON;
      STEP_DATA:  opcode = DATA_OP;
      STEP_POLL:  opcode = STAT_OP;
      STEP_PDIS:  opcode = OP_PROG_OFF;
      STEP_REL:   opcode = OP_RELEASE;
      default:    opcode = OP_SERIAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      step_q  <= STEP_RDBUF;
      pay_q   <= '0;
      fidx_q  <= '0;
      last_q  <= 1'b0;
      timer_q <= '0;
      id_q    <= '0;
      sn_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      if (step_q == STEP_POLL && running && timer_q != T_MAX) timer_q <= timer_q + 1'b1;
      case (st_q)
        C_IDLE: if (start_i) begin
          id_q   <= exp_id_i;
          sn_q   <= exp_sn_i;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          code_q <= ERR_NONE;
          step_q <= STEP_RDBUF;
          pay_q  <= '0;
          last_q <= 1'b0;
          st_q   <= C_LAUNCH;
        end
        C_LAUNCH: if (eng_ready_i) st_q <= C_WAIT;
        C_FILL: if (img_valid_i) begin
          pay_q[fidx_q] <= img_data_i;
          if (img_last_i || fidx_q == FI_LAST) begin
            last_q <= img_last_i;
            step_q <= STEP_DATA;
            st_q   <= C_LAUNCH;
          end else fidx_q <= fidx_q + 1'b1;
        end
        C_WAIT: if (eng_done_i) begin
          case (step_q)
            STEP_RDBUF:
              if (rx_id != id_q) begin
                done_q <= 1'b1; err_q <= 1'b1; code_q <= ERR_ID; st_q <= C_IDLE;
              end else begin
                step_q <= STEP_MODE; st_q <= C_LAUNCH;
              end
            STEP_MODE: begin step_q <= STEP_PEN; st_q <= C_LAUNCH; end
            STEP_PEN: begin
              pay_q <= '0; fidx_q <= '0; step_q <= STEP_DATA; st_q <= C_FILL;
            end
            STEP_DATA: begin
              pay_q <= '0; timer_q <= '0; step_q <= STEP_POLL; st_q <= C_LAUNCH;
            end
            STEP_POLL:
              if (rx_st == STAT_OK) begin
                if (last_q) begin
                  step_q <= STEP_PDIS; st_q <= C_LAUNCH;
                end else begin
                  pay_q <= '0; fidx_q <= '0; step_q <= STEP_DATA; st_q <= C_FILL;
                end
              end else if (rx_st == STAT_BUSY) begin
                if (timer_q >= T_LIM) begin
                  done_q <= 1'b1; err_q <= 1'b1; code_q <= ERR_TIMEOUT; st_q <= C_IDLE;
                end else st_q <= C_LAUNCH;
              end else begin
                done_q <= 1'b1; err_q <= 1'b1; code_q <= ERR_STATUS; st_q <= C_IDLE;
              end
            STEP_PDIS: begin step_q <= STEP_REL; st_q <= C_LAUNCH; end
            STEP_REL:  begin step_q <= STEP_SN;  st_q <= C_LAUNCH; end
            default: begin
              done_q <= 1'b1;
              st_q   <= C_IDLE;
              if (rx_sn != sn_q) begin
                err_q <= 1'b1; code_q <= ERR_SERIAL;
              end
            end
          endcase
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign img_ready_o = (st_q == C_FILL);
  assign eng_go_o    = (st_q == C_LAUNCH) && eng_ready_i;
  assign eng_tx_o    = {opcode, pay_q};
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign err_code_o  = code_q;

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> (done_q && $stable(err_code_o) && $stable(err_q)));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i) |=> ($stable(id_q) && $stable(sn_q)));
  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && code_q == ERR_TIMEOUT) |-> $past(timer_q) >= T_LIM);
endmodule

// File: rtl/spi_prog_seq.sv
`timescale 1ns/1ps
module spi_prog_seq
  import spq_pkg::*;
#(
  parameter int         DIV_HALF    = 4,
  parameter int         CS_GAP      = 4,
  parameter int         TIMEOUT_CYC = 1000000,
  parameter int         ID_W        = 32,
  parameter int         SN_W        = 32,
  parameter logic [7:0] DATA_OP     = 8'h01,
  parameter logic [7:0] STAT_OP     = 8'h05,
  parameter logic [7:0] STAT_OK     = 8'h00,
  parameter logic [7:0] STAT_BUSY   = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [ID_W-1:0] exp_id_i,
  input  logic [SN_W-1:0] exp_sn_i,
  input  logic [7:0]      img_data_i,
  input  logic            img_valid_i,
  input  logic            img_last_i,
  output logic            img_ready_o,
  output logic            spi_sclk_o,
  output logic            spi_mosi_o,
  output logic            spi_cs_n_o,
  input  logic            spi_miso_i,
  output logic            done_o,
  output logic            error_o,
  output logic [3:0]      err_code_o
);
  localparam int CAPW = (ID_W > SN_W) ? ID_W : SN_W;

  logic                     eng_go, eng_ready, eng_done;
  logic [XFER_BYTES*8-1:0]  eng_tx;
  logic [CAPW-1:0]          eng_rx;

  spq_ctrl #(
    .ID_W(ID_W), .SN_W(SN_W), .TIMEOUT_CYC(TIMEOUT_CYC),
    .DATA_OP(DATA_OP), .STAT_OP(STAT_OP), .STAT_OK(STAT_OK),
    .STAT_BUSY(STAT_BUSY), .CAPW(CAPW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .exp_id_i(exp_id_i), .exp_sn_i(exp_sn_i),
    .img_data_i(img_data_i), .img_valid_i(img_valid_i),
    .img_last_i(img_last_i), .img_ready_o(img_ready_o),
    .eng_ready_i(eng_ready), .eng_done_i(eng_done), .eng_rx_i(eng_rx),
    .eng_go_o(eng_go), .eng_tx_o(eng_tx),
    .done_o(done_o), .error_o(error_o), .err_code_o(err_code_o)
  );

  spq_spi_engine #(
    .DIV_HALF(DIV_HALF), .CS_GAP(CS_GAP), .NBYTES(XFER_BYTES), .RXW(CAPW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .go_i(eng_go), .tx_i(eng_tx),
    .ready_o(eng_ready), .done_o(eng_done), .rx_o(eng_rx),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .cs_n_o(spi_cs_n_o),
    .miso_i(spi_miso_i)
  );

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready_o |-> spi_cs_n_o);
endmodule

// File: tb/spi_prog_seq_tb_top.sv
`timescale 1ns/1ps
module spi_prog_seq_tb_top;
  localparam int         DIVH  = 1;
  localparam int         GAPC  = 3;
  localparam int         TMO   = 1500;
  localparam logic [7:0] D_OP  = 8'h01;
  localparam logic [7:0] S_OP  = 8'h05;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [31:0] exp_id, exp_sn;
  logic [7:0]  s_data;
  logic        s_valid, s_last, s_ready;
  logic        sclk, mosi, cs_n, miso;
  logic        done, error;
  logic [3:0]  code;

  spi_prog_seq #(
    .DIV_HALF(DIVH), .CS_GAP(GAPC), .TIMEOUT_CYC(TMO),
    .DATA_OP(D_OP), .STAT_OP(S_OP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .exp_id_i(exp_id), .exp_sn_i(exp_sn),
    .img_data_i(s_data), .img_valid_i(s_valid), .img_last_i(s_last),
    .img_ready_o(s_ready),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_cs_n_o(cs_n), .spi_miso_i(miso),
    .done_o(done), .error_o(error), .err_code_o(code)
  );

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // ---------------- image stream source ----------------
  logic [7:0] smem [0:63];
  int  slen = 0, sidx = 0;
  bit  feed_en = 0, took = 0;

  always @(posedge clk) begin
    took = s_valid && s_ready;
    if (took) sidx <= sidx + 1;
  end

  always @(negedge clk) begin
    if (!feed_en) s_valid = 1'b0;
    else if (!s_valid || took) begin
      if (sidx < slen && $urandom_range(3) != 0) begin
        s_valid = 1'b1;
        s_data  = smem[sidx];
        s_last  = (sidx == slen - 1);
      end else s_valid = 1'b0;
    end
  end

  // ---------------- target device model ----------------
  logic [31:0]  dev_id, dev_sn;
  int           busy_n [0:3];
  int           bad_frame;
  bit           stuck;
  int           bitn = 0, ntx = 0, data_seen = 0, polls_since = 0;
  logic [135:0] rx_sh;
  logic [127:0] resp;
  logic         miso_r = 1'b0;
  logic [7:0]   cmd_log  [0:63];
  logic [127:0] pay_log  [0:63];
  int           bits_log [0:63];
  assign miso = miso_r;

  function automatic logic [127:0] make_resp(input logic [7:0] op);
    logic [7:0] st;
    int f;
    make_resp = '0;
    if (op == 8'h30) make_resp = {dev_id, 96'h0};
    else if (op == 8'h18) make_resp = {dev_sn, 96'h0};
    else if (op == S_OP) begin
      f = data_seen - 1;
      if (stuck) st = 8'h01;
      else if (f == bad_frame) st = 8'h5A;
      else if (f >= 0 && f < 4 && polls_since < busy_n[f]) st = 8'h01;
      else st = 8'h00;
      make_resp = {st, 120'h0};
    end
  endfunction

  always @(negedge cs_n) begin
    bitn = 0; rx_sh = '0; miso_r = 1'b0;
  end
  always @(posedge sclk) if (!cs_n) begin
    rx_sh = {rx_sh[134:0], mosi};
    bitn++;
    if (bitn == 8) resp = make_resp(rx_sh[7:0]);
  end
  always @(negedge sclk) if (!cs_n && bitn >= 8 && bitn < 136)
    miso_r = resp[135 - bitn];
  always @(posedge cs_n) if (bitn > 0) begin
    if (ntx < 64) begin
      cmd_log[ntx]  = rx_sh[135:128];
      pay_log[ntx]  = rx_sh[127:0];
      bits_log[ntx] = bitn;
    end
    ntx++;
    if (rx_sh[135:128] == D_OP) begin data_seen++; polls_since = 0; end
    else if (rx_sh[135:128] == S_OP) polls_since++;
    bitn = 0;
  end

  // ---------------- expected sequence ----------------
  logic [7:0]   exp_cmd [0:63];
  logic [127:0] exp_pay [0:63];
  int           exp_n, exp_code;

  function automatic void push(input logic [7:0] op, input logic [127:0] p);
    if (exp_n < 64) begin exp_cmd[exp_n] = op; exp_pay[exp_n] = p; end
    exp_n++;
  endfunction

  function automatic void build_expected(input int len, input bit id_bad, input bit sn_bad);
    int nfr;
    logic [127:0] p;
    exp_n = 0;
    push(8'h30, '0);
    if (id_bad) begin exp_code = 1; return; end
    push(8'h06, '0);
    push(8'h14, '0);
    nfr = (len + 15) / 16;
    for (int f = 0; f < nfr; f++) begin
      p = '0;
      for (int j = 0; j < 16; j++)
        if (f*16 + j < len) p[127 - 8*j -: 8] = smem[f*16 + j];
      push(D_OP, p);
      if (stuck) begin exp_code = 3; return; end
      if (f == bad_frame) begin push(S_OP, '0); exp_code = 2; return; end
      for (int k = 0; k <= busy_n[f]; k++) push(S_OP, '0);
    end
    push(8'h15, '0);
    push(8'h23, '0);
    push(8'h18, '0);
    exp_code = sn_bad ? 4 : 0;
  endfunction

  function automatic string code_req(input int c);
    case (c)
      1: return "R4";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R9";
    endcase
  endfunction

  // ---------------- one run ----------------
  task automatic run_case(input string nm, input int len, input bit id_bad,
                          input bit sn_bad, input int badf, input bit stk,
                          input bit restart);
    int cyc, bad_cmd, bad_pay, bad_bits, nseen, n0;
    logic [3:0] c0;
    logic [31:0] keep_id, keep_sn;
    feed_en = 0;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    for (int i = 0; i < 64; i++) smem[i] = 8'($urandom);
    for (int f = 0; f < 4; f++) busy_n[f] = $urandom_range(0, 3);
    sidx = 0; slen = len; ntx = 0; data_seen = 0; polls_since = 0;
    bad_frame = badf; stuck = stk;
    dev_id = $urandom; dev_sn = $urandom;
    exp_id = id_bad ? (dev_id ^ 32'h0001_0000) : dev_id;
    exp_sn = sn_bad ? (dev_sn ^ 32'h0000_0080) : dev_sn;
    keep_id = exp_id; keep_sn = exp_sn;
    build_expected(len, id_bad, sn_bad);
    feed_en = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (600) @(negedge clk);
      exp_id = ~keep_id; exp_sn = ~keep_sn;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R10", {nm, " done raised"}, done, 1);
    chk(code == 4'(exp_code), code_req(exp_code), {nm, " result code"}, code, exp_code);
    chk(error == (exp_code != 0), code_req(exp_code), {nm, " error flag"}, error, exp_code != 0);

    bad_cmd = -1; bad_pay = -1; bad_bits = -1;
    nseen = (ntx < 64) ? ntx : 64;
    for (int i = 0; i < nseen; i++) begin
      if (bits_log[i] != 136 && bad_bits < 0) bad_bits = i;
      if (i < exp_n) begin
        if (cmd_log[i] != exp_cmd[i] && bad_cmd < 0) bad_cmd = i;
        if (pay_log[i] != exp_pay[i] && bad_pay < 0) bad_pay = i;
      end else if (!(stuck && cmd_log[i] == S_OP && pay_log[i] == '0) && bad_cmd < 0) bad_cmd = i;
    end
    chk(bad_bits < 0, "R1", {nm, " 136 bits per transfer, first bad index"}, bad_bits, -1);
    chk(bad_cmd < 0, "R3", {nm, " opcode order, first bad index"}, bad_cmd, -1);
    chk(bad_pay < 0, "R5", {nm, " payload bytes, first bad index"}, bad_pay, -1);
    if (stuck) chk(ntx >= exp_n + 1, "R8", {nm, " repeated busy polls"}, ntx, exp_n + 1);
    else       chk(ntx == exp_n, "R3", {nm, " transfer count"}, ntx, exp_n);
    if (exp_code == 0) chk(sidx == len, "R6", {nm, " bytes consumed"}, sidx, len);
    if (id_bad) chk(sidx == 0, "R6", {nm, " no byte taken on identity abort"}, sidx, 0);

    n0 = ntx; c0 = code;
    repeat (40) @(negedge clk);
    chk(code == c0 && done, "R10", {nm, " result held"}, code, c0);
    chk(ntx == n0 && cs_n, "R10", {nm, " no transfer after end"}, ntx, n0);
    chk(s_ready == 1'b0, "R6", {nm, " ready low after end"}, s_ready, 0);
    exp_id = keep_id; exp_sn = keep_sn;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R10 watchdog expired: actual=0x1 expected=0x0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'h00C0_FFEE));
    rst_n = 1'b0; start = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    exp_id = '0; exp_sn = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1,  "R11", "reset select high", cs_n, 1);
    chk(sclk === 1'b0,  "R11", "reset clock low", sclk, 0);
    chk(s_ready === 1'b0, "R11", "reset ready low", s_ready, 0);
    chk(done === 1'b0 && error === 1'b0, "R11", "reset done/error", {done, error}, 0);
    chk(code === 4'd0,  "R11", "reset code", code, 0);

    run_case("one-frame",     16, 0, 0, -1, 0, 0);
    run_case("single-byte",    1, 0, 0, -1, 0, 0);
    run_case("frame-plus-one",17, 0, 0, -1, 0, 0);
    run_case("four-frames",   64, 0, 0, -1, 0, 0);
    run_case("id-mismatch",   20, 1, 0, -1, 0, 0);
    run_case("sn-mismatch",   30, 0, 1, -1, 0, 0);
    run_case("bad-status",    40, 0, 0,  1, 0, 0);
    run_case("stuck-busy",    10, 0, 0, -1, 1, 0);
    run_case("late-start",    33, 0, 0, -1, 0, 1);
    for (int r = 0; r < 6; r++)
      run_case("random", $urandom_range(1, 64), 0, 0, -1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule